// File: doc/BRIEF.md
# Four-phase handshake transfer register

A single-entry holding register that moves data words from a producer to a consumer. Each side uses its own request/acknowledge pair with full return-to-zero signalling. The producer offers a word by raising its request. The register takes the word only when it holds nothing, then acknowledges. On the far side, the register raises its own request while it holds a word and waits for the consumer to acknowledge before it frees itself.

Only one word is ever held. A new word is refused until the consumer side has finished with the old one. As a result no word is dropped and no word is delivered twice. The cost is throughput: a word needs several clock cycles to pass through, depending on how quickly the two partners respond. Both sides run on one clock.

Top module: `hs_xfer_reg`

## Requirements
- R1: After rst_ni is released, p_ack_o and c_req_o are 0, and c_req_o stays 0 while no producer request has been made (the register starts empty).
- R2: While the register is empty and in its idle producer phase, a high p_req_i causes p_data_i to be captured at the next rising edge, and p_ack_o is 1 after that same edge.
- R3: p_ack_o stays 1 while p_req_i stays 1, and returns to 0 at the first rising edge that samples p_req_i low.
- R4: c_req_o rises at the rising edge after the one that captured a word.
- R5: c_data_o equals the captured word and does not change while c_req_o is 1.
- R6: c_req_o returns to 0 at the first rising edge that samples c_ack_i high, and the register is empty from that edge on.
- R7: After c_req_o falls, it is not raised again before c_ack_i has been sampled low. When a word is waiting, it rises at the second edge after c_ack_i goes low.
- R8: While a word is held, p_req_i is not acknowledged (p_ack_o stays 0) and p_data_i has no effect on the held word. The waiting word is captured at the edge after the one that empties the register.
- R9: Every word offered by the producer reaches the consumer exactly once, in the order offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| p_data_i | input | DATA_W | Word from producer |
| p_req_i | input | 1 | Producer request |
| p_ack_o | output | 1 | Acknowledge to producer |
| c_data_o | output | DATA_W | Held word to consumer |
| c_req_o | output | 1 | Request to consumer |
| c_ack_i | input | 1 | Consumer acknowledge |

## Verification
The bench builds the block with DATA_W = 16. At that width the random words almost never repeat, so a lost, duplicated or reordered word shows up in the in-order comparison. Directed sequences pin the exact edge of each handshake transition and hold a second producer request against a full register. Random response delays of zero to three cycles on both partners then bring the cases where a new producer request overlaps the tail of a consumer handshake.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;
  typedef enum logic {IN_IDLE, IN_ACK} in_st_e;
  typedef enum logic [1:0] {OUT_IDLE, OUT_REQ, OUT_DRAIN} out_st_e;
endpackage

// File: rtl/hs_xfer_in.sv
module hs_xfer_in
  import hs_xfer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic p_req_i,
  input  logic full_i,
  output logic p_ack_o,
  output logic capture_o
);
  in_st_e st_q, st_d;

  assign capture_o = (st_q == IN_IDLE) && p_req_i && !full_i;
  assign p_ack_o   = (st_q == IN_ACK);

  always_comb begin
    st_d = st_q;
    case (st_q)
      IN_IDLE: if (capture_o) st_d = IN_ACK;
      IN_ACK:  if (!p_req_i)  st_d = IN_IDLE;
      default: st_d = IN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= IN_IDLE;
    else         st_q <= st_d;

  assert_ack_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(p_ack_o) |-> $past(p_req_i));
  assert_ack_drop_after_req_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(p_ack_o) |-> !$past(p_req_i));
endmodule

// File: rtl/hs_xfer_store.sv
module hs_xfer_store #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else begin
      if (capture_i) begin
        full_o <= 1'b1;
        data_o <= data_i;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
    end

  assert_no_overwrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> !full_o);
  assert_no_double_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_o);
endmodule

// File: rtl/hs_xfer_out.sv
module hs_xfer_out
  import hs_xfer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  input  logic c_ack_i,
  output logic c_req_o,
  output logic take_o
);
  out_st_e st_q, st_d;

  assign c_req_o = (st_q == OUT_REQ);
  assign take_o  = (st_q == OUT_REQ) && c_ack_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      OUT_IDLE:  if (full_i)   st_d = OUT_REQ;
      OUT_REQ:   if (c_ack_i)  st_d = OUT_DRAIN;
      OUT_DRAIN: if (!c_ack_i) st_d = OUT_IDLE;
      default:   st_d = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= OUT_IDLE;
    else         st_q <= st_d;

  assert_req_needs_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_req_o |-> full_i);
  assert_req_drop_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(c_req_o) |-> $past(c_ack_i));
endmodule

// File: rtl/hs_xfer_reg.sv
module hs_xfer_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] p_data_i,
  input  logic              p_req_i,
  output logic              p_ack_o,
  output logic [DATA_W-1:0] c_data_o,
  output logic              c_req_o,
  input  logic              c_ack_i
);
  logic full, capture, take;

  hs_xfer_in u_in (
    .clk_i, .rst_ni, .p_req_i, .full_i(full), .p_ack_o, .capture_o(capture)
  );

  hs_xfer_store #(.DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .capture_i(capture), .take_i(take),
    .data_i(p_data_i), .full_o(full), .data_o(c_data_o)
  );

  hs_xfer_out u_out (
    .clk_i, .rst_ni, .full_i(full), .c_ack_i, .c_req_o, .take_o(take)
  );

  assert_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_req_o && $past(c_req_o)) |-> $stable(c_data_o));
endmodule

// File: tb/hs_xfer_reg_test.sv
`timescale 1ns/1ps
module hs_xfer_reg_test;
  localparam int W = 16;
  localparam int N = 200;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] p_data = '0;
  logic p_req = 0, c_ack = 0;
  logic p_ack, c_req;
  logic [W-1:0] c_data;

  int checks = 0, fails = 0;
  int rx = 0;
  logic [W-1:0] exp_q [N];

  always #2.5 clk = ~clk;

  hs_xfer_reg #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .p_data_i(p_data), .p_req_i(p_req),
    .p_ack_o(p_ack), .c_data_o(c_data), .c_req_o(c_req), .c_ack_i(c_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] gen_word(input int i);
    return W'($urandom) ^ W'(i);
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [W-1:0] v);
    p_data = v; p_req = 1;
    do @(negedge clk); while (!p_ack);
    cyc($urandom_range(0, 3));
    p_req = 0;
    p_data = W'($urandom);
    do @(negedge clk); while (p_ack);
  endtask

  task automatic recv();
    logic [W-1:0] got;
    while (!c_req) @(negedge clk);
    got = c_data;
    for (int d = $urandom_range(0, 3); d > 0; d--) begin
      @(negedge clk);
      chk(c_data == got, "R5", 32'(c_data), 32'(got));
    end
    chk(c_data == exp_q[rx], "R9", 32'(c_data), 32'(exp_q[rx]));
    rx++;
    c_ack = 1;
    do @(negedge clk); while (c_req);
    cyc($urandom_range(0, 3));
    c_ack = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R1: idle after reset, empty
    chk(p_ack == 0, "R1", 32'(p_ack), 0);
    chk(c_req == 0, "R1", 32'(c_req), 0);
    cyc(4);
    chk(c_req == 0, "R1", 32'(c_req), 0);

    // R2/R4: capture A
    p_data = 16'hA5A5; p_req = 1;
    @(negedge clk);
    chk(p_ack == 1, "R2", 32'(p_ack), 1);
    chk(c_req == 0, "R4", 32'(c_req), 0);
    p_data = 16'h1111;
    @(negedge clk);
    chk(c_req == 1, "R4", 32'(c_req), 1);
    chk(c_data == 16'hA5A5, "R5", 32'(c_data), 32'hA5A5);
    chk(p_ack == 1, "R3", 32'(p_ack), 1);
    @(negedge clk);
    chk(p_ack == 1, "R3", 32'(p_ack), 1);
    p_req = 0;
    @(negedge clk);
    chk(p_ack == 0, "R3", 32'(p_ack), 0);

    // R8: second request against full register
    p_data = 16'h3C3C; p_req = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(p_ack == 0, "R8", 32'(p_ack), 0);
      chk(c_data == 16'hA5A5, "R8", 32'(c_data), 32'hA5A5);
    end

    // R6: consumer ack drops c_req
    c_ack = 1;
    @(negedge clk);
    chk(c_req == 0, "R6", 32'(c_req), 0);
    chk(p_ack == 0, "R8", 32'(p_ack), 0);
    @(negedge clk);
    chk(p_ack == 1, "R8", 32'(p_ack), 1);
    chk(c_data == 16'h3C3C, "R8", 32'(c_data), 32'h3C3C);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(c_req == 0, "R7", 32'(c_req), 0);
    end
    c_ack = 0;
    @(negedge clk);
    chk(c_req == 0, "R7", 32'(c_req), 0);
    @(negedge clk);
    chk(c_req == 1, "R7", 32'(c_req), 1);
    chk(c_data == 16'h3C3C, "R5", 32'(c_data), 32'h3C3C);
    p_req = 0;
    c_ack = 1;
    @(negedge clk);
    chk(c_req == 0, "R6", 32'(c_req), 0);
    chk(p_ack == 0, "R3", 32'(p_ack), 0);
    c_ack = 0;
    cyc(3);
    chk(c_req == 0, "R6", 32'(c_req), 0);

    // R9: random traffic
    for (int i = 0; i < N; i++) exp_q[i] = gen_word(i);
    fork
      for (int i = 0; i < N; i++) begin
        send(exp_q[i]);
        cyc($urandom_range(0, 3));
      end
      for (int i = 0; i < N; i++) recv();
    join
    cyc(6);
    chk(rx == N, "R9", 32'(rx), 32'(N));
    chk(c_req == 0, "R9", 32'(c_req), 0);
    finish_run();
  end
endmodule